// File: doc/BRIEF.md
# Channel Stop and Suspend Controller

This block decides when one parallel I/O channel has to stop, and it sequences the stop and the later resume. Three sources can stop the channel: the channel enable bit going low, a clock-stop request from power management, and a debugger halt while the emulation controls select "halt on suspend". Any other setting of those two controls lets the channel run through a debugger halt. The block raises a stop request to the DMA engine as soon as a stop is pending. It waits for a DMA burst already in flight to finish, and only then lets the stop take effect.

Once the stop has taken effect, the behaviour depends on the channel direction. A transmit channel removes the output enable from its data pins and freezes its state machine, so that it can continue from the same point later. A receive channel raises its wait output, still accepts one more incoming word, and then drops every further word until the stop clears. When all stop sources are gone, the frozen state is released on the next clock. If the channel had run before the stop, a one-cycle resume pulse tells the channel state machine to continue from where it was. A reset during a stop discards the frozen context, so no resume pulse follows.

Top module: `chan_stop_ctrl`

## Requirements
- R1: `dma_stop_req` is high in the same cycle as any stop source: `chan_en`=0, `clk_stop_req`=1, or `dbg_halt`=1 with `emu_free`=0 and `emu_soft`=1.
- R2: With `dbg_halt`=1 and any other `emu_free`/`emu_soft` pair (00, 10, 11), the debugger halt causes no stop.
- R3: While `burst_active` is 1, a pending stop does not take effect: `fsm_freeze`, `rx_wait` and `clk_stop_ack` stay 0 and the pins stay enabled. The stop takes effect at the first clock edge at which `burst_active` is 0.
- R4: In transmit mode (`tx_mode`=1), every bit of `pin_oe` is 1 while running and 0 from the clock edge at which the stop takes effect. In receive mode `pin_oe` is always 0.
- R5: A transmit or receive channel that has run since reset holds `fsm_freeze`=1 while stopped. In the cycle in which the last stop source clears, `resume_go` is 1 for exactly one cycle.
- R6: In receive mode, `rx_wait` rises at the clock edge at which the stop takes effect, and the first word presented (`rx_word_valid`=1) after that edge still gets `rx_capture`=1.
- R7: After that one extra word, `rx_capture` stays 0 for every incoming word until the stop clears. In transmit mode `rx_capture` is always 0.
- R8: `clk_stop_ack` is 1 exactly when `clk_stop_req` is 1 and the stop has taken effect, so it is never raised during a burst.
- R9: When all stop sources clear, `fsm_freeze` and `rx_wait` fall at the next clock edge, and from that edge on every incoming word is captured again.
- R10: A reset (`rst_n`=0) during a stop clears the frozen context. If the stop is still pending after the reset, the channel stops again, but `resume_go` stays 0 when that stop clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low peripheral reset |
| chan_en | input | 1 | Channel enable bit |
| clk_stop_req | input | 1 | Clock-stop request from power management |
| dbg_halt | input | 1 | Debugger halt indication |
| emu_free | input | 1 | Emulation control: run freely through a halt |
| emu_soft | input | 1 | Emulation control: stop on a halt when not free |
| tx_mode | input | 1 | 1 = transmit channel, 0 = receive channel |
| burst_active | input | 1 | A DMA burst is in progress |
| rx_word_valid | input | 1 | An incoming word is present this cycle |
| dma_stop_req | output | 1 | Stop pending: DMA must start no new burst |
| clk_stop_ack | output | 1 | Clock-stop acknowledge |
| pin_oe | output | PIN_W | Data pin output enables (transmit) |
| rx_wait | output | 1 | Wait output to the sender (receive) |
| rx_capture | output | 1 | Capture enable for the present word |
| fsm_freeze | output | 1 | Hold the channel state machine |
| resume_go | output | 1 | One-cycle pulse: continue from the frozen state |

## Verification
Two functions can meet in a single cycle in receive mode. The stop can clear in the same cycle in which a word arrives after the extra word has already been taken. The bench provokes this by holding `rx_word_valid` high across the whole stop and dropping `chan_en` back to 1. It expects that word to be dropped (`rx_capture`=0, `resume_go`=1 and `rx_wait` still 1 in that cycle) and the next word to be captured with `rx_wait` low. A second case is a stop source rising while a word is present. That word is still captured before the stop takes effect, and the extra word follows at the next edge.

// File: rtl/csc_pkg.sv
package csc_pkg;
   typedef enum logic [1:0] {
      ST_RUN   = 2'd0,
      ST_DRAIN = 2'd1,
      ST_HALT  = 2'd2
   } stop_st_t;
endpackage

// File: rtl/csc_stop_decode.sv
module csc_stop_decode (
   input  logic chan_en,
   input  logic clk_stop_req,
   input  logic dbg_halt,
   input  logic emu_free,
   input  logic emu_soft,
   output logic stop_pend
);
   logic emu_suspend;
   always_comb begin
      // only the "not free, soft" setting turns a halt into a suspend
      emu_suspend = dbg_halt & ~emu_free & emu_soft;
      stop_pend   = ~chan_en | clk_stop_req | emu_suspend;
   end
endmodule

// File: rtl/csc_stop_seq.sv
module csc_stop_seq
   import csc_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic stop_pend,
   input  logic burst_active,
   input  logic clk_stop_req,
   output logic halted,
   output logic clk_stop_ack,
   output logic resume_go
);
   stop_st_t st_q, st_d;
   logic     ctx_q;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_RUN: begin
            if (stop_pend) st_d = burst_active ? ST_DRAIN : ST_HALT;
         end
         ST_DRAIN: begin
            if (!stop_pend)        st_d = ST_RUN;
            else if (!burst_active) st_d = ST_HALT;
         end
         ST_HALT: begin
            if (!stop_pend) st_d = ST_RUN;
         end
         default: st_d = ST_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_RUN;
         ctx_q <= 1'b0;
      end else begin
         st_q <= st_d;
         // context is worth keeping only once the channel has really run
         if (st_q == ST_RUN && !stop_pend) ctx_q <= 1'b1;
      end
   end

   always_comb begin
      halted       = (st_q == ST_HALT);
      clk_stop_ack = halted & clk_stop_req;
      resume_go    = halted & ~stop_pend & ctx_q;
   end
endmodule

// File: rtl/csc_rx_gate.sv
module csc_rx_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic tx_mode,
   input  logic halted,
   input  logic rx_word_valid,
   output logic rx_capture,
   output logic rx_wait
);
   logic extra_q;

   always_comb begin
      rx_wait    = ~tx_mode & halted;
      rx_capture = ~tx_mode & rx_word_valid & (~halted | ~extra_q);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       extra_q <= 1'b0;
      else if (!halted) extra_q <= 1'b0;
      else if (rx_capture) extra_q <= 1'b1;
   end
endmodule

// File: rtl/csc_tx_pins.sv
module csc_tx_pins #(
   parameter int PIN_W = 16
) (
   input  logic             tx_mode,
   input  logic             halted,
   output logic [PIN_W-1:0] pin_oe
);
   logic drive;
   assign drive = tx_mode & ~halted;

   for (genvar i = 0; i < PIN_W; i++) begin : g_lane
      assign pin_oe[i] = drive;
   end
endmodule

// File: rtl/chan_stop_ctrl.sv
module chan_stop_ctrl #(
   parameter int PIN_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             chan_en,
   input  logic             clk_stop_req,
   input  logic             dbg_halt,
   input  logic             emu_free,
   input  logic             emu_soft,
   input  logic             tx_mode,
   input  logic             burst_active,
   input  logic             rx_word_valid,
   output logic             dma_stop_req,
   output logic             clk_stop_ack,
   output logic [PIN_W-1:0] pin_oe,
   output logic             rx_wait,
   output logic             rx_capture,
   output logic             fsm_freeze,
   output logic             resume_go
);
   initial begin
      assert (PIN_W >= 1 && PIN_W <= 256)
         else $fatal(1, "chan_stop_ctrl: PIN_W out of range");
   end

   logic stop_pend;
   logic halted;

   csc_stop_decode u_dec (
      .chan_en      (chan_en),
      .clk_stop_req (clk_stop_req),
      .dbg_halt     (dbg_halt),
      .emu_free     (emu_free),
      .emu_soft     (emu_soft),
      .stop_pend    (stop_pend)
   );

   csc_stop_seq u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .stop_pend    (stop_pend),
      .burst_active (burst_active),
      .clk_stop_req (clk_stop_req),
      .halted       (halted),
      .clk_stop_ack (clk_stop_ack),
      .resume_go    (resume_go)
   );

   csc_rx_gate u_rx (
      .clk           (clk),
      .rst_n         (rst_n),
      .tx_mode       (tx_mode),
      .halted        (halted),
      .rx_word_valid (rx_word_valid),
      .rx_capture    (rx_capture),
      .rx_wait       (rx_wait)
   );

   csc_tx_pins #(.PIN_W(PIN_W)) u_pins (
      .tx_mode (tx_mode),
      .halted  (halted),
      .pin_oe  (pin_oe)
   );

   assign dma_stop_req = stop_pend;
   assign fsm_freeze   = halted;
endmodule

// File: rtl/csc_checker.sv
module csc_checker #(
   parameter int PIN_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tx_mode,
   input logic             burst_active,
   input logic             clk_stop_req,
   input logic             dma_stop_req,
   input logic             clk_stop_ack,
   input logic [PIN_W-1:0] pin_oe,
   input logic             rx_wait,
   input logic             rx_capture,
   input logic             fsm_freeze
);
   AST_FREEZE_AFTER_BURST: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fsm_freeze) |-> !$past(burst_active)); // R3

   AST_PINS_OFF_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
      fsm_freeze |-> pin_oe == '0); // R4

   AST_ONE_EXTRA_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      (fsm_freeze && $past(fsm_freeze) && $past(rx_capture)) |-> !rx_capture); // R7

   AST_ACK_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      clk_stop_ack |-> (clk_stop_req && fsm_freeze && dma_stop_req)); // R8

   AST_CLEAR_NEXT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      !dma_stop_req |=> (!fsm_freeze && !rx_wait)); // R9

   AST_NO_STOP_UNPENDED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fsm_freeze) |-> $past(dma_stop_req)); // R1

   AST_TX_NO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      tx_mode |-> !rx_capture); // R7
endmodule

bind chan_stop_ctrl csc_checker #(.PIN_W(PIN_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .tx_mode      (tx_mode),
   .burst_active (burst_active),
   .clk_stop_req (clk_stop_req),
   .dma_stop_req (dma_stop_req),
   .clk_stop_ack (clk_stop_ack),
   .pin_oe       (pin_oe),
   .rx_wait      (rx_wait),
   .rx_capture   (rx_capture),
   .fsm_freeze   (fsm_freeze)
);

// File: tb/tb_chan_stop_ctrl.sv
module tb_chan_stop_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int PW = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic chan_en = 1'b1, clk_stop_req = 1'b0, dbg_halt = 1'b0;
   logic emu_free = 1'b0, emu_soft = 1'b0, tx_mode = 1'b1;
   logic burst_active = 1'b0, rx_word_valid = 1'b0;
   logic dma_stop_req, clk_stop_ack, rx_wait, rx_capture, fsm_freeze, resume_go;
   logic [PW-1:0] pin_oe;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   chan_stop_ctrl #(.PIN_W(PW)) dut (
      .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .clk_stop_req(clk_stop_req),
      .dbg_halt(dbg_halt), .emu_free(emu_free), .emu_soft(emu_soft),
      .tx_mode(tx_mode), .burst_active(burst_active), .rx_word_valid(rx_word_valid),
      .dma_stop_req(dma_stop_req), .clk_stop_ack(clk_stop_ack), .pin_oe(pin_oe),
      .rx_wait(rx_wait), .rx_capture(rx_capture), .fsm_freeze(fsm_freeze),
      .resume_go(resume_go)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic idle();
      chan_en = 1'b1; clk_stop_req = 1'b0; dbg_halt = 1'b0;
      emu_free = 1'b0; emu_soft = 1'b0; burst_active = 1'b0; rx_word_valid = 1'b0;
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin : main
      idle();
      tick(); tick();
      // reset state
      chk("R4 reset oe", 32'(pin_oe), 32'({PW{1'b1}}));
      chk("R5 reset freeze", 32'(fsm_freeze), 0);
      chk("R8 reset ack", 32'(clk_stop_ack), 0);
      rst_n = 1'b1;
      tick(); tick();

      // exhaustive sweep of stop sources in both directions
      for (int m = 0; m < 2; m++) begin
         for (int v = 0; v < 32; v++) begin
            logic e, c, h, f, s, stp;
            idle();
            tx_mode = m[0];
            tick();
            e = v[0]; c = v[1]; h = v[2]; f = v[3]; s = v[4];
            stp = ~e | c | (h & ~f & s);
            chan_en = e; clk_stop_req = c; dbg_halt = h; emu_free = f; emu_soft = s;
            rx_word_valid = 1'b1;
            #1;
            chk("R1 stop req", 32'(dma_stop_req), 32'(stp));
            if (h && !(~f & s) && e && !c) chk("R2 halt ignored", 32'(dma_stop_req), 0);
            tick();
            chk("R5 freeze", 32'(fsm_freeze), 32'(stp));
            chk("R8 ack", 32'(clk_stop_ack), 32'(c & stp));
            chk("R4 oe", 32'(pin_oe), (m == 1 && !stp) ? 32'({PW{1'b1}}) : 0);
            chk("R6 wait", 32'(rx_wait), 32'(m == 0 && stp));
            chk("R6 extra word", 32'(rx_capture), 32'(m == 0));
            idle();
            #1;
            chk("R5 resume pulse", 32'(resume_go), 32'(stp));
            tick();
            chk("R9 freeze clear", 32'(fsm_freeze), 0);
         end
      end

      // drain: burst in progress delays the stop
      idle(); tx_mode = 1'b1; tick();
      burst_active = 1'b1; clk_stop_req = 1'b1;
      for (int k = 0; k < 3; k++) begin
         tick();
         chk("R3 no freeze in burst", 32'(fsm_freeze), 0);
         chk("R3 oe kept in burst", 32'(pin_oe), 32'({PW{1'b1}}));
         chk("R8 no ack in burst", 32'(clk_stop_ack), 0);
         chk("R1 req in burst", 32'(dma_stop_req), 1);
      end
      burst_active = 1'b0;
      #1;
      chk("R8 ack waits for edge", 32'(clk_stop_ack), 0);
      tick();
      chk("R3 freeze after burst", 32'(fsm_freeze), 1);
      chk("R8 ack after burst", 32'(clk_stop_ack), 1);
      chk("R4 oe off", 32'(pin_oe), 0);
      idle(); tick();
      chk("R5 tx running again", 32'(pin_oe), 32'({PW{1'b1}}));

      // receive: extra word, drops, same-cycle clear with word
      idle(); tx_mode = 1'b0; rx_word_valid = 1'b1; tick();
      chan_en = 1'b0;
      #1;
      chk("R6 word before stop", 32'(rx_capture), 1);
      tick();
      chk("R6 wait on", 32'(rx_wait), 1);
      chk("R6 extra captured", 32'(rx_capture), 1);
      for (int k = 0; k < 3; k++) begin
         tick();
         chk("R7 word dropped", 32'(rx_capture), 0);
      end
      chan_en = 1'b1;
      #1;
      chk("R7 dropped at clear", 32'(rx_capture), 0);
      chk("R9 wait still on", 32'(rx_wait), 1);
      chk("R5 rx resume pulse", 32'(resume_go), 1);
      tick();
      chk("R9 wait off", 32'(rx_wait), 0);
      chk("R9 capture resumes", 32'(rx_capture), 1);
      tx_mode = 1'b1;
      #1;
      chk("R7 tx no capture", 32'(rx_capture), 0);

      // reset during a stop
      idle(); tx_mode = 1'b1; tick();
      chan_en = 1'b0; tick();
      chk("R10 stopped before reset", 32'(fsm_freeze), 1);
      rst_n = 1'b0; tick();
      rst_n = 1'b1; tick();
      chk("R10 stops again", 32'(fsm_freeze), 1);
      chan_en = 1'b1;
      #1;
      chk("R10 no resume", 32'(resume_go), 0);
      tick();
      chk("R10 runs fresh", 32'(fsm_freeze), 0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule